// File: doc/BRIEF.md
# Load/Store Address and Lane Steering Unit

This block sits between the register read stage and data memory of a 32-bit load-store processor. It receives an already separated six-bit opcode, the base register value, the 16-bit displacement from the instruction, the register value to be stored, and the word read from memory. From these it forms the effective address, the word address sent to memory, per-byte write enables, the store data placed on the correct byte lanes, and the extended load result. It also raises a flag when an access is not aligned to its own size.

The block holds no state and every output is a combinational function of the current inputs. Byte lanes follow big-endian numbering, so byte offset 0 within a word is bits [31:24] and byte offset 3 is bits [7:0]. Three opcodes load and three store, at byte, halfword and word size. Any other opcode leaves memory untouched and drives the data outputs to zero.

Top module: `lsu_addr_unit`

## Requirements
- R1: effAddr equals baseVal plus offsetImm sign-extended to 32 bits, modulo 2^32.
- R2: wordAddr equals effAddr[31:2].
- R3: Opcodes 0x20, 0x21, 0x23 are loads of byte, halfword and word; 0x28, 0x29, 0x2B are stores of byte, halfword and word. Any other opcode gives byteWe = 0, memWdata = 0, loadResult = 0 and misaligned = 0.
- R4: A byte store at byte offset k = effAddr[1:0] enables exactly lane bit byteWe[3-k], where byteWe[3] covers bits [31:24] and byteWe[0] covers bits [7:0].
- R5: An aligned halfword store gives byteWe = 4'b1100 at offset 0 and 4'b0011 at offset 2; an aligned word store gives 4'b1111.
- R6: On a store, memWdata holds storeData[7:0] copied to all four lanes for a byte, storeData[15:0] copied to both halves for a halfword, and storeData unchanged for a word; it is zero when the opcode is not a store.
- R7: A byte load returns the byte at offset k (bits [31-8k:24-8k] of memRdata) sign-extended to 32 bits.
- R8: A halfword load returns memRdata[31:16] when effAddr[1] is 0 and memRdata[15:0] when it is 1, sign-extended to 32 bits; effAddr[0] does not move the selection.
- R9: A word load returns memRdata unchanged; loadResult is zero when the opcode is not a load.
- R10: misaligned is 1 exactly when a halfword access has effAddr[0] = 1 or a word access has effAddr[1:0] not equal to 0.
- R11: A misaligned store asserts no write enable.
- R12: A load never asserts a write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 6 | Opcode field of the memory instruction |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement from the instruction |
| storeData | input | 32 | Data register value for stores |
| memRdata | input | 32 | Word read from data memory |
| effAddr | output | 32 | Effective byte address |
| wordAddr | output | 30 | Word address to data memory |
| byteWe | output | 4 | Per-lane write enables, bit 3 is bits [31:24] |
| memWdata | output | 32 | Store data on byte lanes |
| loadResult | output | 32 | Extended load value |
| misaligned | output | 1 | Access not aligned to its size |

## Verification
The six opcodes are each applied at all four byte offsets, which separates a correct big-endian lane map from a reversed one and shows which offsets count as misaligned for each size. Memory words whose bytes differ and carry alternating sign bits show whether a load picks the right lane and extends with the sign rather than zeros. Negative displacements and a base near the top of the address space reveal a missing sign extension of the offset or a lost carry. Unused opcodes with non-zero data confirm that nothing reaches memory or the load result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic     rdEn;
    logic     wrEn;
    accSize_e size;
  } lsuCtrl_t;

  localparam logic [5:0] OP_LD_B = 6'h20;
  localparam logic [5:0] OP_LD_H = 6'h21;
  localparam logic [5:0] OP_LD_W = 6'h23;
  localparam logic [5:0] OP_ST_B = 6'h28;
  localparam logic [5:0] OP_ST_H = 6'h29;
  localparam logic [5:0] OP_ST_W = 6'h2B;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic [OP_W-1:0] opCode,
  output lsuCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{rdEn: 1'b0, wrEn: 1'b0, size: SZ_BYTE};
    case (opCode)
      OP_LD_B: ctrl = '{rdEn: 1'b1, wrEn: 1'b0, size: SZ_BYTE};
      OP_LD_H: ctrl = '{rdEn: 1'b1, wrEn: 1'b0, size: SZ_HALF};
      OP_LD_W: ctrl = '{rdEn: 1'b1, wrEn: 1'b0, size: SZ_WORD};
      OP_ST_B: ctrl = '{rdEn: 1'b0, wrEn: 1'b1, size: SZ_BYTE};
      OP_ST_H: ctrl = '{rdEn: 1'b0, wrEn: 1'b1, size: SZ_HALF};
      OP_ST_W: ctrl = '{rdEn: 1'b0, wrEn: 1'b1, size: SZ_WORD};
      default: ;
    endcase
  end

  always_comb begin
    AST_DECODE_EXCLUSIVE: assert (!(ctrl.rdEn && ctrl.wrEn)) else $error("load and store both decoded"); // R3
  end

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  lsuCtrl_t                     ctrl,
  input  logic [ADDR_W-1:0]            baseVal,
  input  logic [OFF_W-1:0]             offsetImm,
  input  logic [DATA_W-1:0]            storeData,
  input  logic [DATA_W-1:0]            memRdata,
  output logic [ADDR_W-1:0]            effAddr,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] wordAddr,
  output logic [DATA_W/8-1:0]          byteWe,
  output logic [DATA_W-1:0]            memWdata,
  output logic [DATA_W-1:0]            loadResult,
  output logic                         misaligned
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int HALVES = LANES / 2;

  logic [LANE_W-1:0] laneSel;
  logic [LANES-1:0]  laneHit;
  logic              memOp;
  logic [DATA_W-1:0] byteShift;
  logic [DATA_W-1:0] halfShift;
  logic [7:0]        byteVal;
  logic [15:0]       halfVal;

  assign effAddr  = baseVal + {{(ADDR_W-OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
  assign wordAddr = effAddr[ADDR_W-1:LANE_W];
  assign laneSel  = effAddr[LANE_W-1:0];
  assign memOp    = ctrl.rdEn | ctrl.wrEn;

  always_comb begin
    misaligned = 1'b0;
    if (memOp) begin
      case (ctrl.size)
        SZ_HALF: misaligned = laneSel[0];
        SZ_WORD: misaligned = |laneSel;
        default: misaligned = 1'b0;
      endcase
    end
  end

  // Lane i counts from the most significant byte (offset 0) downward
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneHit[LANES-1-i] =
      (ctrl.size == SZ_WORD) ? 1'b1 :
      (ctrl.size == SZ_HALF) ? (laneSel[LANE_W-1:1] == (LANE_W-1)'(i / 2)) :
                               (laneSel == LANE_W'(i));
  end

  assign byteWe = (ctrl.wrEn && !misaligned) ? laneHit : '0;

  always_comb begin
    memWdata = '0;
    if (ctrl.wrEn) begin
      case (ctrl.size)
        SZ_BYTE: memWdata = {LANES{storeData[7:0]}};
        SZ_HALF: memWdata = {HALVES{storeData[15:0]}};
        default: memWdata = storeData;
      endcase
    end
  end

  assign byteShift = memRdata >> (8 * (LANES - 1 - int'(laneSel)));
  assign halfShift = memRdata >> (16 * (HALVES - 1 - int'(laneSel[LANE_W-1:1])));
  assign byteVal   = byteShift[7:0];
  assign halfVal   = halfShift[15:0];

  always_comb begin
    loadResult = '0;
    if (ctrl.rdEn) begin
      case (ctrl.size)
        SZ_BYTE: loadResult = {{(DATA_W-8){byteVal[7]}}, byteVal};
        SZ_HALF: loadResult = {{(DATA_W-16){halfVal[15]}}, halfVal};
        default: loadResult = memRdata;
      endcase
    end
  end

  always_comb begin
    AST_MISALIGN_NO_WE: assert (!(misaligned && (byteWe != '0))) else $error("write enable on misaligned access"); // R11
    AST_LOAD_NO_WE: assert (!(ctrl.rdEn && (byteWe != '0))) else $error("write enable during load"); // R12
    AST_BYTE_ONE_LANE: assert (!(ctrl.wrEn && ctrl.size == SZ_BYTE) || $countones(byteWe) == 1) else $error("byte store lane count"); // R4
    AST_WORD_ALL_LANES: assert (!(ctrl.wrEn && ctrl.size == SZ_WORD && !misaligned) || (&byteWe)) else $error("word store lanes"); // R5
    AST_MISALIGN_MEMOP: assert (!misaligned || memOp) else $error("misaligned without memory op"); // R10
  end

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int OP_W   = 6
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] wordAddr,
  output logic [DATA_W/8-1:0] byteWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadResult,
  output logic              misaligned
);

  lsuCtrl_t ctrl;

  lsu_decode #(.OP_W(OP_W)) u_decode (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  lsu_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_datapath (
    .ctrl       (ctrl),
    .baseVal    (baseVal),
    .offsetImm  (offsetImm),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .effAddr    (effAddr),
    .wordAddr   (wordAddr),
    .byteWe     (byteWe),
    .memWdata   (memWdata),
    .loadResult (loadResult),
    .misaligned (misaligned)
  );

endmodule

// File: tb/sim_lsu_addr_unit.sv
`timescale 1ns/1ps
module sim_lsu_addr_unit;

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] st;
    logic [31:0] rd;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{6'h23, 32'h0000_1000, 16'h0010, 32'h0,          32'hDEAD_BEEF},
    '{6'h23, 32'h0000_1000, 16'hFFFC, 32'h0,          32'h1234_5678},
    '{6'h23, 32'h0000_1001, 16'h0000, 32'h0,          32'h1234_5678},
    '{6'h21, 32'h0000_2000, 16'h0000, 32'h0,          32'h8001_7FFE},
    '{6'h21, 32'h0000_2000, 16'h0002, 32'h0,          32'h8001_7FFE},
    '{6'h21, 32'h0000_2000, 16'h0003, 32'h0,          32'h8001_F00D},
    '{6'h20, 32'h0000_3000, 16'h0001, 32'h0,          32'h11A2_3344},
    '{6'h20, 32'h0000_3003, 16'hFFFF, 32'h0,          32'h1122_B344},
    '{6'h2B, 32'h0000_4000, 16'h0008, 32'hCAFE_F00D,  32'h0},
    '{6'h2B, 32'h0000_4002, 16'h0000, 32'hCAFE_F00D,  32'h0},
    '{6'h29, 32'h0000_5000, 16'h0002, 32'h1234_ABCD,  32'h0},
    '{6'h29, 32'h0000_5000, 16'h0001, 32'h1234_ABCD,  32'h0},
    '{6'h28, 32'h8000_0000, 16'h8002, 32'hFFFF_FF5A,  32'h0},
    '{6'h22, 32'h0000_0004, 16'h0001, 32'hFFFF_FFFF,  32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]  opCode;
  logic [31:0] baseVal, storeData, memRdata;
  logic [15:0] offsetImm;
  logic [31:0] effAddr, memWdata, loadResult;
  logic [29:0] wordAddr;
  logic [3:0]  byteWe;
  logic        misaligned;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  lsu_addr_unit u0 (
    .opCode(opCode), .baseVal(baseVal), .offsetImm(offsetImm),
    .storeData(storeData), .memRdata(memRdata), .effAddr(effAddr),
    .wordAddr(wordAddr), .byteWe(byteWe), .memWdata(memWdata),
    .loadResult(loadResult), .misaligned(misaligned)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired: actual %0d cycles expected under 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    logic [31:0] ea, expWd, expLd;
    logic [3:0]  expWe;
    logic [1:0]  k;
    logic        isLd, isSt, mis;
    logic [7:0]  b;
    logic [15:0] h;
    int          sz;
    @(posedge clk);
    opCode = v.op; baseVal = v.base; offsetImm = v.off;
    storeData = v.st; memRdata = v.rd;
    ea = v.base + {{16{v.off[15]}}, v.off};
    k = ea[1:0];
    isLd = (v.op == 6'h20) || (v.op == 6'h21) || (v.op == 6'h23);
    isSt = (v.op == 6'h28) || (v.op == 6'h29) || (v.op == 6'h2B);
    sz = (v.op[1:0] == 2'b00) ? 1 : (v.op[1:0] == 2'b01) ? 2 : 4;
    mis = (isLd || isSt) && ((sz == 2 && k[0]) || (sz == 4 && k != 2'b00));
    expWe = 4'b0000; expWd = 32'h0; expLd = 32'h0;
    if (isSt) begin
      if (sz == 1) begin
        expWd = {4{v.st[7:0]}};
        case (k) 2'd0: expWe = 4'b1000; 2'd1: expWe = 4'b0100;
                 2'd2: expWe = 4'b0010; default: expWe = 4'b0001; endcase
      end else if (sz == 2) begin
        expWd = {2{v.st[15:0]}};
        expWe = k[1] ? 4'b0011 : 4'b1100;
      end else begin
        expWd = v.st; expWe = 4'b1111;
      end
      if (mis) expWe = 4'b0000;
    end
    if (isLd) begin
      case (k) 2'd0: b = v.rd[31:24]; 2'd1: b = v.rd[23:16];
               2'd2: b = v.rd[15:8];  default: b = v.rd[7:0]; endcase
      h = k[1] ? v.rd[15:0] : v.rd[31:16];
      if (sz == 1) expLd = {{24{b[7]}}, b};
      else if (sz == 2) expLd = {{16{h[15]}}, h};
      else expLd = v.rd;
    end
    @(negedge clk);
    chk("R1", "effAddr", effAddr, ea);
    chk("R2", "wordAddr", {2'b00, wordAddr}, {2'b00, ea[31:2]});
    chk(mis ? "R11" : (isLd ? "R12" : (sz == 1 ? "R4" : "R5")), "byteWe", {28'h0, byteWe}, {28'h0, expWe});
    chk(isSt ? "R6" : "R3", "memWdata", memWdata, expWd);
    chk(!isLd ? "R3" : (sz == 1 ? "R7" : (sz == 2 ? "R8" : "R9")), "loadResult", loadResult, expLd);
    chk("R10", "misaligned", {31'h0, misaligned}, {31'h0, mis});
  endtask

  initial begin
    opCode = 6'h00; baseVal = '0; offsetImm = '0; storeData = '0; memRdata = '0;
    @(negedge clk);
    // idle state: no memory opcode, all data outputs quiet
    chk("R3", "idle byteWe", {28'h0, byteWe}, 32'h0);
    chk("R3", "idle misaligned", {31'h0, misaligned}, 32'h0);
    chk("R1", "idle effAddr", effAddr, 32'h0);

    for (int i = 0; i < NVEC; i++) apply(VECS[i]);

    // every opcode at every byte offset
    for (int o = 0; o < 6; o++) begin
      for (int k = 0; k < 4; k++) begin
        logic [5:0] op;
        case (o) 0: op = 6'h20; 1: op = 6'h21; 2: op = 6'h23;
                 3: op = 6'h28; 4: op = 6'h29; default: op = 6'h2B; endcase
        apply('{op, 32'h0000_0100 + 32'(k), 16'h0000, 32'h0102_83F4, 32'h80FF_7F01});
      end
    end

    // carry wrap at top of address space (R1)
    apply('{6'h23, 32'hFFFF_FFFE, 16'h0006, 32'h0, 32'hA5A5_5A5A});
    // most negative displacement (R1)
    apply('{6'h2B, 32'h0000_0000, 16'h8000, 32'h7654_3210, 32'h0});
    // unused opcode with loud data (R3)
    apply('{6'h2A, 32'h0000_0010, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
    apply('{6'h3F, 32'h0000_0013, 16'h0000, 32'hFFFF_FFFF, 32'h8000_0000});

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule